// File: doc/BRIEF.md
# Shared-Pin Core Reset and NMI Router

This block lets one set of board pins drive the local reset and the non-maskable interrupt of several processor cores. A 3-bit core-select input picks one core, or all cores at once. One reset-request pin and one interrupt-request pin say what to do. An active-low strobe says when the other pins are valid. All pins are asynchronous to the system clock, so each one passes through a two-flop synchronizer before use.

The block captures the select and request pins once, on the falling edge of the synchronized strobe. It decodes them into a target set and a command, and then updates the outputs of the targeted cores only. The local reset of each core is a held level. It is set by a reset command and cleared only by a later release command. The interrupt of each core is a single-clock pulse. A reset request outranks an interrupt request given in the same strobe.

Top module: `core_evt_router`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, every bit of `core_rst_o` and `core_nmi_o` is 0.
- R2: While `pin_stb_ni` stays high, no combination of `pin_sel_i`, `pin_rst_ni` and `pin_nmi_ni` changes `core_rst_o` or raises any `core_nmi_o` bit.
- R3: With the strobe falling and select values 000, 001, 010 or 011, only core 0, 1, 2 or 3 (bit 0..3 of the outputs) is affected. The other cores keep their state.
- R4: A select value with bit 2 set (1xx) applies the command to all four cores.
- R5: A strobe with `pin_rst_ni` = 0 sets `core_rst_o` of the targeted cores to 1 and produces no interrupt pulse, whatever `pin_nmi_ni` holds.
- R6: A strobe with `pin_rst_ni` = 1 and `pin_nmi_ni` = 0 raises `core_nmi_o` of the targeted cores for exactly one clock and leaves `core_rst_o` unchanged.
- R7: A strobe with `pin_rst_ni` = 1 and `pin_nmi_ni` = 1 clears `core_rst_o` of the targeted cores and produces no interrupt pulse.
- R8: A core's `core_rst_o` stays at 1 until a release command reaches that core. Interrupt commands and idle time do not change it.
- R9: Outputs change on the 4th rising clock edge after the strobe pin falls. After the 3rd edge they still show the old state.
- R10: Keeping the strobe low causes no second action, even if the other pins change. A new command needs the strobe to rise and then fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| pin_sel_i | input | 3 | Core select. Bit 2 set means all cores; otherwise bits 1:0 give the core index |
| pin_rst_ni | input | 1 | Reset request, active low, asynchronous |
| pin_nmi_ni | input | 1 | Interrupt request, active low, asynchronous |
| pin_stb_ni | input | 1 | Active-low strobe that qualifies the other pins, asynchronous |
| core_rst_o | output | 4 | Held local-reset level per core, active high |
| core_nmi_o | output | 4 | One-clock interrupt pulse per core, active high |

## Verification
A command takes three register stages to reach the decode: two synchronizer flops and the capture register. The output register adds a fourth, so results are due on the 4th rising edge after the bench drops the strobe. Each scenario task drives the pins on a falling clock edge. It samples once after three rising edges, where the old state must still show, and once after the fourth, where the new state is due. It samples a third time one clock later to confirm the interrupt pulse has ended. Strobe-high sweeps and the held-low case are checked on every clock over a window longer than that latency.

// File: rtl/core_evt_pkg.sv
package core_evt_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE     = 2'd0,
    CMD_HOLD_RST = 2'd1,
    CMD_FIRE_NMI = 2'd2,
    CMD_RELEASE  = 2'd3
  } core_cmd_e;

endpackage

// File: rtl/cer_sync.sv
module cer_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/cer_capture.sv
module cer_capture #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_n_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rst_req_n_i,
  input  logic             nmi_req_n_i,
  output logic             vld_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             rst_req_n_o,
  output logic             nmi_req_n_o
);

  logic stb_n_q;
  logic fall;

  assign fall = stb_n_q & ~stb_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_n_q     <= 1'b1;
      vld_o       <= 1'b0;
      sel_o       <= '0;
      rst_req_n_o <= 1'b1;
      nmi_req_n_o <= 1'b1;
    end else begin
      stb_n_q <= stb_n_i;
      vld_o   <= fall;
      if (fall) begin
        sel_o       <= sel_i;
        rst_req_n_o <= rst_req_n_i;
        nmi_req_n_o <= nmi_req_n_i;
      end
    end
  end

  AST_CAP_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o); // R10

endmodule

// File: rtl/cer_decode.sv
module cer_decode
  import core_evt_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned SEL_W     = 3
) (
  input  logic                 vld_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 rst_req_n_i,
  input  logic                 nmi_req_n_i,
  output logic [NUM_CORES-1:0] hit_o,
  output core_cmd_e            cmd_o
);

  localparam int unsigned LO_W = SEL_W - 1;

  logic bcast;
  assign bcast = sel_i[SEL_W-1];

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_hit
    assign hit_o[i] = vld_i & (bcast | (sel_i[LO_W-1:0] == LO_W'(i)));
  end

  // reset request outranks interrupt request
  always_comb begin
    if (!vld_i)            cmd_o = CMD_IDLE;
    else if (!rst_req_n_i) cmd_o = CMD_HOLD_RST;
    else if (!nmi_req_n_i) cmd_o = CMD_FIRE_NMI;
    else                   cmd_o = CMD_RELEASE;
  end

  always_comb begin
    if (vld_i && !bcast) begin
      AST_SINGLE_TARGET: assert ($onehot0(hit_o)); // R3
    end
  end

endmodule

// File: rtl/cer_out_bank.sv
module cer_out_bank
  import core_evt_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic [NUM_CORES-1:0] hit_i,
  input  core_cmd_e            cmd_i,
  output logic [NUM_CORES-1:0] rst_lvl_o,
  output logic [NUM_CORES-1:0] nmi_pls_o
);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rst_lvl_o[i] <= 1'b0;
        nmi_pls_o[i] <= 1'b0;
      end else begin
        nmi_pls_o[i] <= 1'b0;
        if (hit_i[i]) begin
          unique case (cmd_i)
            CMD_HOLD_RST: rst_lvl_o[i] <= 1'b1;
            CMD_RELEASE:  rst_lvl_o[i] <= 1'b0;
            CMD_FIRE_NMI: nmi_pls_o[i] <= 1'b1;
            default: ;
          endcase
        end
      end
    end

    AST_NMI_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_pls_o[i] |=> !nmi_pls_o[i]); // R6
    AST_RST_RISE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_lvl_o[i]) |-> !nmi_pls_o[i]); // R5
    AST_RST_FALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rst_lvl_o[i]) |-> !nmi_pls_o[i]); // R7
  end

  AST_RST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(rst_lvl_o)); // R8

endmodule

// File: rtl/core_evt_router.sv
module core_evt_router
  import core_evt_pkg::*;
#(
  parameter int unsigned NUM_CORES   = 4,
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SEL_W-1:0]     pin_sel_i,
  input  logic                 pin_rst_ni,
  input  logic                 pin_nmi_ni,
  input  logic                 pin_stb_ni,
  output logic [NUM_CORES-1:0] core_rst_o,
  output logic [NUM_CORES-1:0] core_nmi_o
);

  localparam int unsigned BUS_W = SEL_W + 3;
  localparam logic [BUS_W-1:0] SYNC_RST = {3'b111, {SEL_W{1'b0}}};

  logic [BUS_W-1:0] pin_bus, sync_bus;
  logic [SEL_W-1:0] s_sel, c_sel;
  logic             s_stb_n, s_rst_n, s_nmi_n;
  logic             c_vld, c_rst_n, c_nmi_n;
  logic [NUM_CORES-1:0] hit;
  core_cmd_e        cmd;

  assign pin_bus = {pin_stb_ni, pin_rst_ni, pin_nmi_ni, pin_sel_i};
  assign {s_stb_n, s_rst_n, s_nmi_n, s_sel} = sync_bus;

  cer_sync #(
    .W       (BUS_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_bus),
    .q_o    (sync_bus)
  );

  cer_capture #(.SEL_W(SEL_W)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stb_n_i     (s_stb_n),
    .sel_i       (s_sel),
    .rst_req_n_i (s_rst_n),
    .nmi_req_n_i (s_nmi_n),
    .vld_o       (c_vld),
    .sel_o       (c_sel),
    .rst_req_n_o (c_rst_n),
    .nmi_req_n_o (c_nmi_n)
  );

  cer_decode #(.NUM_CORES(NUM_CORES), .SEL_W(SEL_W)) u_dec (
    .vld_i       (c_vld),
    .sel_i       (c_sel),
    .rst_req_n_i (c_rst_n),
    .nmi_req_n_i (c_nmi_n),
    .hit_o       (hit),
    .cmd_o       (cmd)
  );

  cer_out_bank #(.NUM_CORES(NUM_CORES)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (c_vld),
    .hit_i     (hit),
    .cmd_i     (cmd),
    .rst_lvl_o (core_rst_o),
    .nmi_pls_o (core_nmi_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_vld |=> (core_nmi_o == '0)); // R2

endmodule

// File: tb/core_evt_router_tb_top.sv
module core_evt_router_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b000;
  logic       rq_rst_n = 1'b1;
  logic       rq_nmi_n = 1'b1;
  logic       stb_n = 1'b1;
  logic [3:0] core_rst, core_nmi;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] exp_rst = 4'h0;

  always #4 clk = ~clk; // 125 MHz

  core_evt_router dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pin_sel_i  (sel),
    .pin_rst_ni (rq_rst_n),
    .pin_nmi_ni (rq_nmi_n),
    .pin_stb_ni (stb_n),
    .core_rst_o (core_rst),
    .core_nmi_o (core_nmi)
  );

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // one strobe pulse carrying a command; checks latency, result and pulse end
  task automatic issue(input logic [2:0] s, input logic r, input logic n);
    logic [3:0] mask, nxt_rst, exp_nmi;
    string      tgt, act;
    mask = s[2] ? 4'hf : 4'(1 << s[1:0]);
    tgt  = s[2] ? "R4" : "R3";
    nxt_rst = exp_rst;
    exp_nmi = 4'h0;
    if (!r)      begin nxt_rst = exp_rst | mask;  act = "R5"; end
    else if (!n) begin exp_nmi = mask;            act = "R6"; end
    else         begin nxt_rst = exp_rst & ~mask; act = "R7"; end
    @(negedge clk);
    sel = s; rq_rst_n = r; rq_nmi_n = n; stb_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 rst before due edge", core_rst, exp_rst);
    chk("R9 nmi before due edge", core_nmi, 4'h0);
    @(posedge clk);
    @(negedge clk);
    chk({tgt, " ", act, " rst"}, core_rst, nxt_rst);
    chk({tgt, " ", act, " nmi"}, core_nmi, exp_nmi);
    exp_rst = nxt_rst;
    @(posedge clk);
    @(negedge clk);
    chk("R6 nmi pulse ends", core_nmi, 4'h0);
    stb_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset_state;
    repeat (3) @(negedge clk);
    chk("R1 rst in reset", core_rst, 4'h0);
    chk("R1 nmi in reset", core_nmi, 4'h0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 rst after reset", core_rst, 4'h0);
    chk("R1 nmi after reset", core_nmi, 4'h0);
  endtask

  task automatic t_strobe_high;
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      stb_n = 1'b1; sel = c[2:0]; rq_rst_n = c[3]; rq_nmi_n = c[4];
      repeat (5) begin
        @(negedge clk);
        chk("R2 rst with strobe high", core_rst, exp_rst);
        chk("R2 nmi with strobe high", core_nmi, 4'h0);
      end
    end
  endtask

  task automatic t_sweep;
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 4; k++)
        issue(3'(s), k[1], k[0]);
  endtask

  task automatic t_hold;
    issue(3'b010, 1'b0, 1'b1);
    issue(3'b010, 1'b1, 1'b0);
    chk("R8 rst kept after nmi", {3'b000, core_rst[2]}, 4'h1);
    repeat (20) @(negedge clk);
    chk("R8 rst kept idle", core_rst, exp_rst);
    issue(3'b000, 1'b1, 1'b1);
    chk("R8 other core untouched by release", {3'b000, core_rst[2]}, 4'h1);
    issue(3'b010, 1'b1, 1'b1);
  endtask

  task automatic t_no_retrigger;
    @(negedge clk);
    sel = 3'b001; rq_rst_n = 1'b1; rq_nmi_n = 1'b0; stb_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 first nmi", core_nmi, 4'h2);
    sel = 3'b100; rq_rst_n = 1'b0;
    repeat (12) begin
      @(negedge clk);
      chk("R10 held strobe rst", core_rst, exp_rst);
      chk("R10 held strobe nmi", core_nmi, 4'h0);
    end
    stb_n = 1'b1;
    repeat (8) begin
      @(negedge clk);
      chk("R10 strobe rise no action", core_rst, exp_rst);
    end
  endtask

  initial begin
    t_reset_state();
    t_strobe_high();
    t_sweep();
    t_hold();
    t_no_retrigger();
    issue(3'b111, 1'b0, 1'b0);
    issue(3'b101, 1'b1, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule